// File: doc/BRIEF.md
# Count-to-Limit Interval Timer

A 32-bit interval timer that counts upward by one on every clock while it is running. Software loads a start value and an end value through a small register port. When the counter has reached the end value, the next increment returns it to zero and sets a pending flag. A level interrupt output follows that flag while interrupts are enabled.

A write to the control register is the acknowledge. It replaces the enable and run bits and clears the pending flag. Two typical uses are a periodic or one-shot event tick (end value = interval, start value = 0) and a free-running monotonic counter (end value = all ones, interrupt off).

Register map, selected by `addr_i`: 0 = control, 1 = counter value, 2 = end value, 3 = unused (reads zero). Control layout: bit 0 = interrupt enable, bit 1 = run, bit 3 = pending. Every other control bit reads zero.

Top module: `interval_timer`

## Requirements
- R1: After an asynchronous reset (rst_ni low), every register reads zero and irq_o is 0.
- R2: A write to address 0 stores wdata_i bit 0 as interrupt enable and bit 1 as run. Reads of address 0 return enable at bit 0, run at bit 1 and pending at bit 3. All other bits read zero, and write data bits 2 and up have no effect.
- R3: While run is 1, the counter value rises by one on each clock. While run is 0, it holds its value, even when it equals the end value.
- R4: When run is 1 and the counter equals the end value, the next clock loads zero into the counter and sets pending (control bit 3).
- R5: irq_o is 1 exactly when pending and interrupt enable are both 1.
- R6: A control write clears pending. If a wrap happens in the same cycle, pending is set instead.
- R7: A write to address 1 loads wdata_i into the counter on the next clock. It takes priority over the increment and the wrap in that cycle.
- R8: A write to address 2 sets the end value, which reads back at address 2. Address 3 always reads zero.
- R9: With the end value at all ones and run set, the counter steps from 32'hFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The embedded properties check these on every cycle:
- a halted counter holds its value;
- a running counter steps by one or wraps to zero at the end value;
- a counter write lands exactly;
- a wrap always leaves pending set;
- pending only rises after a wrap;
- a plain control write clears pending.

Only the bench scenarios can show the rest:
- the read-data map and the zero bits in the control word;
- the gating of the interrupt by the enable bit;
- the ack/wrap collision;
- the free-running rollover at the 32-bit maximum;
- the register state after a reset in the middle of a run.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int DW = 32;
  localparam int AW = 2;

  typedef enum logic [AW-1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_LIMIT = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  localparam int CTRL_IE_BIT  = 0;
  localparam int CTRL_RUN_BIT = 1;
  localparam int CTRL_PND_BIT = 3;
endpackage

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
  import itmr_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ctrl_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         wrap_i,
  output logic         ie_o,
  output logic         run_o,
  output logic         pend_o
);
  logic ie_q, run_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      run_q <= 1'b0;
    end else if (ctrl_we_i) begin
      ie_q  <= wdata_i[CTRL_IE_BIT];
      run_q <= wdata_i[CTRL_RUN_BIT];
    end
  end

  // a wrap in the ack cycle wins so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (wrap_i)    pend_q <= 1'b1;
    else if (ctrl_we_i) pend_q <= 1'b0;
  end

  assign ie_o   = ie_q;
  assign run_o  = run_q;
  assign pend_o = pend_q;

  // R6
  pend_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !wrap_i) |=> !pend_o);
  // R6
  pend_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> pend_o);
  // R4
  pend_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(wrap_i));
endmodule

// File: rtl/itmr_cnt.sv
module itmr_cnt
  import itmr_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         count_we_i,
  input  logic         limit_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] limit_o,
  output logic         wrap_o
);
  logic [W-1:0] count_q, limit_q, count_d;
  logic         at_limit;

  assign at_limit = (count_q == limit_q);
  assign wrap_o   = run_i && !count_we_i && at_limit;

  always_comb begin
    count_d = count_q;
    if (count_we_i)  count_d = wdata_i;
    else if (run_i)  count_d = at_limit ? '0 : count_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         limit_q <= '0;
    else if (limit_we_i) limit_q <= wdata_i;
  end

  assign count_o = count_q;
  assign limit_o = limit_q;

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !count_we_i) |=> $stable(count_o));
  // R3
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !count_we_i && (count_o != limit_o)) |=> (count_o == $past(count_o) + 1'b1));
  // R4
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (count_o == '0));
  // R7
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_we_i |=> (count_o == $past(wdata_i)));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic          ctrl_we, count_we, limit_we;
  logic          ie, run, pend, wrap;
  logic [DW-1:0] count, limit, ctrl_word;

  assign ctrl_we  = we_i && (addr_i == REG_CTRL);
  assign count_we = we_i && (addr_i == REG_COUNT);
  assign limit_we = we_i && (addr_i == REG_LIMIT);

  itmr_ctrl #(.W(DW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (ctrl_we),
    .wdata_i   (wdata_i),
    .wrap_i    (wrap),
    .ie_o      (ie),
    .run_o     (run),
    .pend_o    (pend)
  );

  itmr_cnt #(.W(DW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .count_we_i (count_we),
    .limit_we_i (limit_we),
    .wdata_i    (wdata_i),
    .count_o    (count),
    .limit_o    (limit),
    .wrap_o     (wrap)
  );

  always_comb begin
    ctrl_word               = '0;
    ctrl_word[CTRL_IE_BIT]  = ie;
    ctrl_word[CTRL_RUN_BIT] = run;
    ctrl_word[CTRL_PND_BIT] = pend;
  end

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      REG_CTRL:  rdata_o = ctrl_word;
      REG_COUNT: rdata_o = count;
      REG_LIMIT: rdata_o = limit;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = pend && ie;

  // R5
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie && $rose(pend)) |-> irq_o);
endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          total = 0;
  int          bad = 0;

  always #5 clk = ~clk;

  interval_timer u_interval_timer (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic        chk;
    logic [31:0] exp;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd2, 32'd3,  1'b0, 32'd0,  1'b0, 4'd8}, // R8 end value = 3
    '{1'b1, 2'd1, 32'd1,  1'b0, 32'd0,  1'b0, 4'd7}, // R7 load 1
    '{1'b1, 2'd0, 32'd3,  1'b0, 32'd0,  1'b0, 4'd2}, // R2 enable + run
    '{1'b0, 2'd1, 32'd0,  1'b1, 32'd1,  1'b0, 4'd7},
    '{1'b0, 2'd1, 32'd0,  1'b1, 32'd2,  1'b0, 4'd3}, // R3 step
    '{1'b0, 2'd1, 32'd0,  1'b1, 32'd3,  1'b0, 4'd3},
    '{1'b0, 2'd0, 32'd0,  1'b1, 32'd11, 1'b1, 4'd4}, // R4 wrap sets bit 3
    '{1'b0, 2'd1, 32'd0,  1'b1, 32'd1,  1'b1, 4'd4}, // R4 restarted at 0
    '{1'b1, 2'd0, 32'd1,  1'b1, 32'd11, 1'b1, 4'd5}, // R5 ack, halt
    '{1'b0, 2'd0, 32'd0,  1'b1, 32'd1,  1'b0, 4'd6}, // R6 cleared
    '{1'b0, 2'd1, 32'd0,  1'b1, 32'd3,  1'b0, 4'd3},
    '{1'b0, 2'd1, 32'd0,  1'b1, 32'd3,  1'b0, 4'd3}, // R3 halted at limit
    '{1'b1, 2'd0, 32'd2,  1'b0, 32'd0,  1'b0, 4'd2}, // run, irq off
    '{1'b0, 2'd1, 32'd0,  1'b1, 32'd3,  1'b0, 4'd3},
    '{1'b0, 2'd0, 32'd0,  1'b1, 32'd10, 1'b0, 4'd5}, // R5 pending, gated
    '{1'b1, 2'd1, 32'd7,  1'b0, 32'd0,  1'b0, 4'd7}, // R7 load while running
    '{1'b0, 2'd1, 32'd0,  1'b1, 32'd7,  1'b0, 4'd7},
    '{1'b0, 2'd2, 32'd0,  1'b1, 32'd3,  1'b0, 4'd8},
    '{1'b0, 2'd3, 32'd0,  1'b1, 32'd0,  1'b0, 4'd8}, // R8 unused reads 0
    '{1'b0, 2'd0, 32'd0,  1'b1, 32'd10, 1'b0, 4'd6}
  };

  task automatic step(input logic w, input logic [1:0] a, input logic [31:0] d,
                      input logic chk, input logic [31:0] exp, input logic xirq,
                      input int req);
    @(negedge clk);
    we = w; addr = a; wdata = d;
    #1;
    if (chk) begin
      total++;
      if (rdata !== exp) begin
        bad++;
        $display("FAIL R%0d rdata addr=%0d actual=%h expected=%h", req, a, rdata, exp);
      end
    end
    total++;
    if (irq !== xirq) begin
      bad++;
      $display("FAIL R%0d irq actual=%b expected=%b", req, irq, xirq);
    end
  endtask

  task automatic idle_read(input logic [1:0] a, input logic [31:0] exp,
                           input logic xirq, input int req);
    step(1'b0, a, 32'd0, 1'b1, exp, xirq, req);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    idle_read(2'd0, 32'd0, 1'b0, 1);
    idle_read(2'd1, 32'd0, 1'b0, 1);
    idle_read(2'd2, 32'd0, 1'b0, 1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      step(TBL[i].we, TBL[i].addr, TBL[i].wdata, TBL[i].chk,
           TBL[i].exp, TBL[i].irq, int'(TBL[i].req));

    // R2 upper write bits ignored
    step(1'b1, 2'd0, 32'hFFFF_FFFC, 1'b0, 32'd0, 1'b0, 2);
    idle_read(2'd0, 32'd0, 1'b0, 2);

    // R9 free-running rollover at max
    step(1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0, 32'd0, 1'b0, 9);
    step(1'b1, 2'd1, 32'hFFFF_FFFE, 1'b0, 32'd0, 1'b0, 9);
    step(1'b1, 2'd0, 32'd2,         1'b0, 32'd0, 1'b0, 9);
    idle_read(2'd1, 32'hFFFF_FFFE, 1'b0, 9);
    idle_read(2'd1, 32'hFFFF_FFFF, 1'b0, 9);
    idle_read(2'd1, 32'd0,         1'b0, 9);
    idle_read(2'd0, 32'd10,        1'b0, 9);

    // R6 wrap in the same cycle as an ack keeps pending
    step(1'b1, 2'd0, 32'd0, 1'b0, 32'd0, 1'b0, 6);
    step(1'b1, 2'd2, 32'd5, 1'b0, 32'd0, 1'b0, 6);
    step(1'b1, 2'd1, 32'd4, 1'b0, 32'd0, 1'b0, 6);
    step(1'b1, 2'd0, 32'd2, 1'b0, 32'd0, 1'b0, 6);
    idle_read(2'd1, 32'd4, 1'b0, 6);
    step(1'b1, 2'd0, 32'd3, 1'b0, 32'd0, 1'b0, 6);
    idle_read(2'd0, 32'd11, 1'b1, 6);
    idle_read(2'd1, 32'd1, 1'b1, 6);

    // R1 reset in the middle of a run
    @(negedge clk);
    we = 1'b0;
    rst_n = 1'b0;
    #1;
    total++;
    if (irq !== 1'b0) begin
      bad++;
      $display("FAIL R1 irq after reset actual=%b expected=0", irq);
    end
    idle_read(2'd1, 32'd0, 1'b0, 1);
    idle_read(2'd2, 32'd0, 1'b0, 1);
    idle_read(2'd0, 32'd0, 1'b0, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule